// File: doc/BRIEF.md
# Palette Colour Store with Streaming Index

This block holds the colour palette bytes of a tile-based display engine: 128 bytes, the lower 64 used for background palettes and the upper 64 for object (sprite) palettes. Software reaches each half through a pair of registers. One register is a pointer that selects a byte within its half. The other is a data window that reads or writes the byte under that pointer. When a pointer is loaded with its streaming flag set, every write through the matching data window moves the pointer on by one. A whole palette set can therefore be loaded with one pointer write followed by a burst of data writes.

The pixel pipeline has its own read-only lookup port. It takes a 7-bit byte address and returns the stored byte combinationally. It never disturbs either pointer. Turning palette bytes into colours is left to the logic downstream.

Top module: `palette_store`

## Requirements
- R1: The store holds 128 bytes. `lookup_addr` 0 to 63 address the background half and 64 to 127 the object half, and `lookup_data` shows the byte at `lookup_addr` in the same cycle.
- R2: `reg_sel` encoding: bit 1 picks the half (0 background, 1 object) and bit 0 picks the pointer (0) or the data window (1). A write to a pointer loads write-data bits 5:0 as the byte pointer and bit 7 as the streaming flag. Bit 6 is discarded.
- R3: A write to the background data window (`reg_sel`=1) stores the write data at byte address equal to the background pointer.
- R4: A write to the object data window (`reg_sel`=3) stores the write data at byte address 64 plus the object pointer.
- R5: With the streaming flag set, each data-window write advances that half's 6-bit pointer by one, wrapping from 63 to 0. With the flag clear, the pointer stays where it is.
- R6: Reading a data window returns the byte under that half's pointer and leaves the pointer unchanged.
- R7: Reading a pointer returns the streaming flag in bit 7, a constant 1 in bit 6 and the pointer in bits 5:0.
- R8: A synchronous active-low reset clears all 128 bytes, both pointers and both streaming flags.
- R9: Writes aimed at one half change neither the pointer nor the flag of the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe for one cycle |
| reg_sel | input | 2 | Register select: bit 1 = half, bit 0 = data window |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read of the selected register |
| lookup_addr | input | 7 | Pixel-pipeline byte address |
| lookup_data | output | 8 | Byte stored at `lookup_addr` |

## Verification
The bench streams a full 64-byte burst through the background window and then goes past it. A pointer that ran to 64 instead of wrapping would leak the extra bytes into the object half, and this shows up in a sweep of all 128 lookup addresses. An object burst is started mid-half so that it wraps. A design that left out the 64 offset, or that stepped the wrong pointer, would overwrite background bytes or move the background pointer. Single writes with the flag clear, pointer writes with bit 6 toggled, and back-to-back data-window reads check in turn for a pointer that moves without the flag, a bit 6 that is stored, and a read that advances the pointer. A reset in the middle of the run must bring every byte and both pointers back to zero.

// File: rtl/pal_pkg.sv
// Shared definitions for the palette colour store.
// Assumes an 8-bit register layout: streaming flag in the top bit, and one
// constant-one filler bit above a 6-bit byte pointer.
package pal_pkg;
    // register select: bit 1 = half (0 background, 1 object), bit 0 = data window
    typedef enum logic [1:0] {
        SEL_BG_PTR  = 2'd0,
        SEL_BG_DAT  = 2'd1,
        SEL_OBJ_PTR = 2'd2,
        SEL_OBJ_DAT = 2'd3
    } pal_sel_e;

    localparam int NUM_HALVES = 2;
endpackage

// File: rtl/pal_ptr_reg.sv
// Byte pointer plus streaming flag for one half of the palette store.
// A load captures the pointer and the flag from the write data. A step moves
// the pointer on by one (modulo 2**PTR_W) only while the flag is set.
// Assumes load and step never arrive in the same cycle; load wins if they do.
module pal_ptr_reg #(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              stream_o
);
    logic [PTR_W-1:0] ptr_q;
    logic             stream_q;

    // pointer and flag update: reset, load from software, or streaming step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            stream_q <= 1'b0;
        end else if (load) begin
            ptr_q    <= wdata[PTR_W-1:0];
            stream_q <= wdata[DATA_W-1];
        end else if (step && stream_q) begin
            ptr_q    <= ptr_q + 1'b1;
        end
    end

    assign ptr_o    = ptr_q;
    assign stream_o = stream_q;

    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (ptr_q == '0 && !stream_q));

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr_q == $past(wdata[PTR_W-1:0]) && stream_q == $past(wdata[DATA_W-1])));

    assert_stream_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && stream_q && !load) |=> (ptr_q == PTR_W'($past(ptr_q) + 1)));

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(ptr_q) && $stable(stream_q)));
endmodule

// File: rtl/pal_ram.sv
// Flop-based palette byte array with one write port and two combinational
// read ports (one for the register window, one for the pixel lookup).
// Assumes it is small enough that resetting every entry is affordable.
module pal_ram #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // storage update: clear everything on reset, otherwise one byte per write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // combinational read ports
    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/palette_store.sv
// Palette colour store: 2**(PTR_W+1) bytes split into a background half and
// an object half, each reached through a pointer/data-window register pair,
// plus a read-only lookup port for the pixel pipeline.
// Assumes DATA_W = PTR_W + 2 (flag bit, one filler bit reading 1, pointer).
module palette_store #(
    parameter int PTR_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [PTR_W:0]    lookup_addr,
    output logic [DATA_W-1:0] lookup_data
);
    import pal_pkg::*;

    localparam int ADDR_W = PTR_W + 1;
    localparam int PAD_W  = DATA_W - 1 - PTR_W;

    logic             sel_half;
    logic             sel_data;
    logic             half_load [NUM_HALVES];
    logic             half_step [NUM_HALVES];
    logic [PTR_W-1:0] half_ptr  [NUM_HALVES];
    logic             half_strm [NUM_HALVES];
    logic [DATA_W-1:0] half_view [NUM_HALVES];

    logic              ram_we;
    logic [ADDR_W-1:0] win_addr;
    logic [DATA_W-1:0] win_data;

    assign sel_half = reg_sel[1];
    assign sel_data = reg_sel[0];

    // one pointer register per half, with its load/step strobes and read view
    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        assign half_load[g] = reg_wr_en && !sel_data && (sel_half == 1'(g));
        assign half_step[g] = reg_wr_en &&  sel_data && (sel_half == 1'(g));

        pal_ptr_reg #(
            .PTR_W  (PTR_W),
            .DATA_W (DATA_W)
        ) ptr_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (half_load[g]),
            .wdata    (reg_wdata),
            .step     (half_step[g]),
            .ptr_o    (half_ptr[g]),
            .stream_o (half_strm[g])
        );

        assign half_view[g] = {half_strm[g], {PAD_W{1'b1}}, half_ptr[g]};
    end

    // the data window addresses the selected half: half bit on top of its pointer
    always_comb begin
        win_addr = {sel_half, half_ptr[sel_half]};
        ram_we   = reg_wr_en && sel_data;
    end

    pal_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) ram_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ram_we),
        .waddr   (win_addr),
        .wdata   (reg_wdata),
        .raddr_a (win_addr),
        .rdata_a (win_data),
        .raddr_b (lookup_addr),
        .rdata_b (lookup_data)
    );

    // register read mux: data window byte or pointer view
    always_comb begin
        unique case (pal_sel_e'(reg_sel))
            SEL_BG_PTR:  reg_rdata = half_view[0];
            SEL_OBJ_PTR: reg_rdata = half_view[1];
            default:     reg_rdata = win_data;
        endcase
    end

    assert_bg_leaves_obj_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_sel[1]) |=> ($stable(half_ptr[1]) && $stable(half_strm[1])));

    assert_obj_leaves_bg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_sel[1]) |=> ($stable(half_ptr[0]) && $stable(half_strm[0])));

    assert_obj_upper_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && reg_sel[1]) |-> win_addr[ADDR_W-1]);
endmodule

// File: tb/palette_store_tb_top.sv
module palette_store_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr_en;
    logic [1:0] reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [6:0] lookup_addr;
    logic [7:0] lookup_data;

    always #5 clk = ~clk;

    palette_store dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .lookup_addr (lookup_addr),
        .lookup_data (lookup_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] m_mem [128];
    logic [5:0] m_ptr [2];
    logic       m_str [2];

    task automatic check(input string req, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
        for (int h = 0; h < 2; h++) begin m_ptr[h] = 6'd0; m_str[h] = 1'b0; end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // write one register and update the bench model
    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        int h;
        h = int'(sel[1]);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (!sel[0]) begin
            m_ptr[h] = d[5:0];
            m_str[h] = d[7];
        end else begin
            m_mem[h * 64 + int'(m_ptr[h])] = d;
            if (m_str[h]) m_ptr[h] = m_ptr[h] + 6'd1;
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] v);
        reg_wr_en = 1'b0; reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic check_ptr(input int h, input string req);
        logic [7:0] v;
        rd(2'(h * 2), v);
        check(req, $sformatf("pointer view half %0d", h), int'(v), int'({m_str[h], 1'b1, m_ptr[h]}));
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 128; a++) begin
            lookup_addr = 7'(a);
            #1;
            check(req, $sformatf("lookup byte %0d", a), int'(lookup_data), int'(m_mem[a]));
        end
    endtask

    bit finished = 1'b0;

    initial begin
        #2000000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00; lookup_addr = 7'd0;
        model_clear();
        do_reset();

        // R8 R7: reset state
        sweep("R8");
        check_ptr(0, "R8 R7");
        check_ptr(1, "R8 R7");

        // R3 R5: full background burst with streaming, then past the wrap
        wr(2'd0, 8'h80);
        for (int i = 0; i < 67; i++) begin
            wr(2'd1, 8'(i * 7 + 3));
            check_ptr(0, "R5");
        end
        check_ptr(1, "R9");
        sweep("R3 R1");

        // R4 R5 R9: object burst from the middle, wrapping
        wr(2'd2, 8'hA0);
        for (int i = 0; i < 40; i++) begin
            wr(2'd3, 8'(i * 13 + 8'h55));
            check_ptr(1, "R5");
        end
        check_ptr(0, "R9");
        sweep("R4 R1");

        // R5: flag clear holds the pointer
        wr(2'd0, 8'h05);
        wr(2'd1, 8'hAA);
        wr(2'd1, 8'hBB);
        check_ptr(0, "R5");
        lookup_addr = 7'd5; #1;
        check("R5", "held-pointer byte", int'(lookup_data), 8'hBB);

        // R2 R7: bit 6 discarded, filler reads 1
        wr(2'd0, 8'h7F);
        check_ptr(0, "R2");
        wr(2'd0, 8'hC1);
        check_ptr(0, "R2");
        wr(2'd2, 8'h40);
        check_ptr(1, "R2");

        // R6: data reads return the byte and do not move the pointer
        wr(2'd0, 8'h8A);
        rd(2'd1, v);
        check("R6", "bg window read", int'(v), int'(m_mem[10]));
        rd(2'd1, v);
        check("R6", "bg window reread", int'(v), int'(m_mem[10]));
        @(negedge clk);
        check_ptr(0, "R6");
        wr(2'd2, 8'h83);
        rd(2'd3, v);
        check("R6", "obj window read", int'(v), int'(m_mem[67]));
        @(negedge clk);
        check_ptr(1, "R6");

        // R8: reset after traffic clears everything
        do_reset();
        sweep("R8");
        check_ptr(0, "R8");
        check_ptr(1, "R8");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule